// File: doc/BRIEF.md
# Leading-Edge Boost Gate Timer

This block is the digital timing core of a boost converter controller. It runs on a fast sampling clock in which one main-clock period spans `STEPS` sub-steps. A three-state cycle sequencer divides the main clock by three. Each resulting switching frame is `3*STEPS` fast cycles long. Only the first main period of a frame is a gate window. During that window a ramp counter climbs from 0 to `STEPS-1`. Outside the window the gate is held low. This caps the gate duty at one third.

The gate uses leading-edge modulation. An error code comes from an external amplifier or converter. The gate latch sets at the first window step whose ramp value reaches that code. The latch then holds until the window closes, and the gate falls on the first step after the window. The channel runs only while the enable input is high and the disable strap is low. The enable input is shared with the main 5 V buck channel, so both channels start together. The strap marks a channel with its feedback tied to the always-on 5 V rail. If the channel is stopped, the sequencer, the ramp and the latch all return to their idle values.

Sequencer states: `ST_IDLE` (channel stopped), `ST_RAMP` (gate window), `ST_GAP_A` and `ST_GAP_B` (the two dead periods). The transitions are:
- IDLE→RAMP when the channel becomes active.
- RAMP→GAP_A, GAP_A→GAP_B and GAP_B→RAMP, each on the last sub-step of a period.
- Any state→IDLE when the channel becomes inactive.

Top module: `boost_le_pwm`

## Requirements
- R1: While the channel is active, gate windows repeat every `3*STEPS` fast cycles (192 by default). With a constant error code, successive rising edges of the gate are exactly that far apart.
- R2: The gate is high only during the first `STEPS` steps of a frame, which are window steps 0..`STEPS-1`. It is low in all other steps of the frame.
- R3: The error code is unsigned and `$clog2(STEPS)+1` bits wide. The gate rises at the first window step k with k ≥ error code, where k counts from 0 and the code is the value present on the clock edge that starts step k.
- R4: Once set, the gate stays high through window step `STEPS-1`, even if the error code rises above the ramp. It falls on the first step after the window.
- R5: An error code of `STEPS` or more produces no gate pulse in that frame.
- R6: An error code of 0 produces a gate pulse covering the whole window, which is `STEPS` steps.
- R7: When enable drops, the gate is low from the next step onward. When enable returns, a new window starts at step 0 on the step after enable is first seen high.
- R8: During reset the gate is low, and after reset the channel stays idle until it is enabled.
- R9: A high disable strap stops the channel in the same way as a low enable, whatever the enable input is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, `STEPS` cycles per main-clock period |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Channel enable, shared with the main 5 V buck channel |
| strap_i | input | 1 | Disable strap; high when feedback is tied to the always-on rail |
| err_i | input | ERR_W | Error code compared against the ramp (7 bits by default) |
| gate_o | output | 1 | Boost switch gate drive |

## Verification
A wrong sequencer state shows up as a gate pulse at the wrong spacing or as a pulse inside a dead period. This appears at the latest within one frame of 192 cycles. A wrong ramp value or a wrong comparison moves the rising edge of the gate off its expected step within the first window. A latch that fails to hold or fails to clear shows up within a single window, as a gap in the pulse or as a gate still high on the step after the window. Because of this, the bench compares the gate with an independent step model on every cycle.

// File: rtl/boost_le_pwm_pkg.sv
package boost_le_pwm_pkg;

    // Divide-by-three frame sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RAMP  = 2'd1,
        ST_GAP_A = 2'd2,
        ST_GAP_B = 2'd3
    } frame_state_e;

endpackage

// File: rtl/blp_ramp_ctr.sv
module blp_ramp_ctr #(
    parameter int STEPS  = 64,
    parameter int RAMP_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              started_i,
    output logic [RAMP_W-1:0] sub_q_o,
    output logic [RAMP_W-1:0] sub_d_o,
    output logic              wrap_o
);
    localparam logic [RAMP_W-1:0] LAST = RAMP_W'(STEPS - 1);

    logic [RAMP_W-1:0] sub_q;
    logic [RAMP_W-1:0] sub_d;

    assign wrap_o = started_i && (sub_q == LAST);

    always_comb begin
        if (!run_i || !started_i) begin
            sub_d = '0;
        end else if (sub_q == LAST) begin
            sub_d = '0;
        end else begin
            sub_d = sub_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q <= '0;
        end else begin
            sub_q <= sub_d;
        end
    end

    assign sub_q_o = sub_q;
    assign sub_d_o = sub_d;

    // R2: the sub-step counter never leaves its range
    a_r2_sub_range : assert property (@(posedge clk) disable iff (!rst_n)
        sub_q <= LAST);

    // R7: a stopped channel restarts its sub-step count from zero
    a_r7_sub_cleared : assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> sub_q == '0);

endmodule

// File: rtl/blp_frame_fsm.sv
module blp_frame_fsm
    import boost_le_pwm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         wrap_i,
    output frame_state_e state_q_o,
    output frame_state_e state_d_o,
    output logic         started_o
);
    frame_state_e state_q;
    frame_state_e state_d;

    // next-state process
    always_comb begin
        state_d = state_q;
        if (!run_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_RAMP;
                ST_RAMP:  if (wrap_i) state_d = ST_GAP_A;
                ST_GAP_A: if (wrap_i) state_d = ST_GAP_B;
                ST_GAP_B: if (wrap_i) state_d = ST_RAMP;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output process
    always_comb begin
        started_o = (state_q != ST_IDLE);
        state_q_o = state_q;
        state_d_o = state_d;
    end

    // R1: window is followed by the first dead period
    a_r1_ramp_to_gap : assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && state_q == ST_RAMP && wrap_i) |=> state_q == ST_GAP_A);

    // R1: second dead period leads back into a window
    a_r1_gap_to_ramp : assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && state_q == ST_GAP_B && wrap_i) |=> state_q == ST_RAMP);

    // R9: an inactive channel rests in the idle state
    a_r9_idle_when_off : assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> state_q == ST_IDLE);

endmodule

// File: rtl/blp_gate_latch.sv
module blp_gate_latch #(
    parameter int RAMP_W = 6,
    parameter int ERR_W  = RAMP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_d_i,
    input  logic [RAMP_W-1:0] ramp_d_i,
    input  logic [ERR_W-1:0]  err_i,
    output logic              gate_o
);
    logic gate_q;
    logic set_c;
    logic hold_c;
    logic gate_d;

    // Set when the upcoming ramp value reaches the error code
    assign set_c  = win_d_i && ({1'b0, ramp_d_i} >= err_i);
    // Keep a set latch until the window closes (ramp restarts or leaves)
    assign hold_c = win_d_i && (ramp_d_i != '0) && gate_q;
    assign gate_d = set_c || hold_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign gate_o = gate_q;

    // R4: a set gate drops only when the window is left or restarted
    a_r4_latch_holds : assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && win_d_i && ramp_d_i != '0) |=> gate_q);

endmodule

// File: rtl/boost_le_pwm.sv
module boost_le_pwm
    import boost_le_pwm_pkg::*;
#(
    parameter int STEPS  = 64,
    parameter int RAMP_W = $clog2(STEPS),
    parameter int ERR_W  = RAMP_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             strap_i,
    input  logic [ERR_W-1:0] err_i,
    output logic             gate_o
);
    logic              run;
    logic              wrap;
    logic              started;
    logic [RAMP_W-1:0] sub_q;
    logic [RAMP_W-1:0] sub_d;
    frame_state_e      state_q;
    frame_state_e      state_d;
    logic              win_d;

    assign run   = enable_i && !strap_i;
    assign win_d = (state_d == ST_RAMP);

    blp_ramp_ctr #(.STEPS(STEPS), .RAMP_W(RAMP_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .started_i (started),
        .sub_q_o   (sub_q),
        .sub_d_o   (sub_d),
        .wrap_o    (wrap)
    );

    blp_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .wrap_i    (wrap),
        .state_q_o (state_q),
        .state_d_o (state_d),
        .started_o (started)
    );

    blp_gate_latch #(.RAMP_W(RAMP_W), .ERR_W(ERR_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_d_i  (win_d),
        .ramp_d_i (sub_d),
        .err_i    (err_i),
        .gate_o   (gate_o)
    );

    // R2: gate is confined to the window state
    a_r2_gate_in_window : assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> state_q == ST_RAMP);

    // R3: a rising gate means the ramp has reached the code
    a_r3_rise_at_level : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> ({1'b0, sub_q} >= $past(err_i)));

    // R4: gate falls only on leaving the window or on a stop
    a_r4_fall_at_end : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_o) |-> (state_q == ST_GAP_A || state_q == ST_IDLE));

    // R9: a strapped or disabled channel drives the gate low
    a_r9_off_low : assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !gate_o);

endmodule

// File: tb/boost_le_pwm_test.sv
module boost_le_pwm_test;
    localparam int CLK_P = 10;
    localparam int STEPS = 64;
    localparam int FRAME = 3 * STEPS;
    localparam int ERR_W = $clog2(STEPS) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable_i = 1'b0;
    logic             strap_i = 1'b0;
    logic [ERR_W-1:0] err_i = '0;
    logic             gate_o;

    int n_checks = 0;
    int n_errors = 0;
    int pos = -1;
    bit exp_gate = 1'b0;
    int cyc = 0;

    boost_le_pwm #(.STEPS(STEPS)) uut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .strap_i(strap_i),
        .err_i(err_i), .gate_o(gate_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d, step %0d)", req, act, exp, cyc, pos);
        end
    endtask

    function automatic string tag_for(int p, int e);
        if (p < 0)       return "R7";
        if (p >= STEPS)  return "R2";
        if (e >= STEPS)  return "R5";
        if (e == 0)      return "R6";
        return "R3";
    endfunction

    // Independent step model plus per-cycle comparison
    always @(posedge clk) begin
        int e;
        e = int'(err_i);
        if (!rst_n || !enable_i || strap_i) begin
            pos = -1;
            exp_gate = 1'b0;
        end else begin
            pos = (pos < 0) ? 0 : (pos + 1) % FRAME;
            if (pos < STEPS) exp_gate = ((pos != 0) && exp_gate) || (pos >= e);
            else             exp_gate = 1'b0;
        end
        cyc++;
        #(CLK_P/4);
        chk(gate_o == exp_gate, tag_for(pos, e), int'(gate_o), int'(exp_gate));
    end

    task automatic wait_pos(input int p);
        do @(negedge clk); while (pos != p);
    endtask

    task automatic wait_gate(input bit v);
        do @(negedge clk); while (gate_o != v);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int t0;
        int t1;
        int hi;
        void'($urandom(32'h5eed_b005));
        repeat (3) @(negedge clk);
        chk(gate_o == 1'b0, "R8", int'(gate_o), 0);          // R8 reset state
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(gate_o == 1'b0, "R8", int'(gate_o), 0);          // R8 idle until enabled
        err_i = 7'd20;
        enable_i = 1'b1;

        // random codes, changed during the dead periods
        for (int i = 0; i < 60; i++) begin
            wait_pos(100);
            err_i = ERR_W'($urandom_range(0, 80));
        end

        // R6: code zero gives a full-window pulse
        wait_pos(100); err_i = '0;
        wait_pos(0); hi = 0;
        for (int k = 0; k < FRAME; k++) begin
            if (gate_o) hi++;
            @(negedge clk);
        end
        chk(hi == STEPS, "R6", hi, STEPS);

        // R5: full scale and above give no pulse
        wait_pos(100); err_i = ERR_W'(STEPS);
        wait_pos(100); err_i = '1;
        wait_pos(STEPS / 2);
        chk(gate_o == 1'b0, "R5", int'(gate_o), 0);

        // R3: code 63 gives a single-step pulse at the last window step
        wait_pos(100); err_i = ERR_W'(STEPS - 1);
        wait_pos(STEPS - 1);
        chk(gate_o == 1'b1, "R3", int'(gate_o), 1);

        // R1: period between rising edges
        wait_pos(100); err_i = 7'd30;
        wait_gate(1'b1); t0 = cyc;
        wait_gate(1'b0);
        wait_gate(1'b1); t1 = cyc;
        chk(t1 - t0 == FRAME, "R1", t1 - t0, FRAME);

        // R4: raising the code mid-window does not clear the gate
        wait_pos(100); err_i = 7'd10;
        wait_pos(20); err_i = 7'd60;
        wait_pos(40);
        chk(gate_o == 1'b1, "R4", int'(gate_o), 1);
        wait_pos(STEPS);
        chk(gate_o == 1'b0, "R4", int'(gate_o), 0);

        // R7: stop mid-pulse, then restart
        wait_pos(100); err_i = 7'd10;
        wait_pos(30);
        enable_i = 1'b0;
        @(negedge clk);
        chk(gate_o == 1'b0, "R7", int'(gate_o), 0);
        repeat (7) @(negedge clk);
        enable_i = 1'b1;
        repeat (12) @(negedge clk);
        chk(gate_o == 1'b1, "R7", int'(gate_o), 1);     // window restarted at step 0

        // R9: strap overrides enable
        wait_pos(5); err_i = '0;
        strap_i = 1'b1;
        hi = 0;
        for (int k = 0; k < 2 * FRAME; k++) begin
            @(negedge clk);
            if (gate_o) hi++;
        end
        chk(hi == 0, "R9", hi, 0);
        strap_i = 1'b0;

        for (int i = 0; i < 20; i++) begin
            wait_pos(100);
            err_i = ERR_W'($urandom_range(0, 127));
        end
        wait_pos(150);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule